// File: doc/BRIEF.md
# Second-Level Cache Line Refill Engine with Sequential Prefetch

This block handles misses for an eight-way unified second-level cache whose lines are twice as wide as the system bus. When it accepts a demand miss, it builds the line from two bus beats, lower half first. It then hands the whole line, together with a way chosen by least-recently-used order, to the cache arrays. The block keeps its own copy of the tags, valid bits and per-way age counters. A hit port lets the cache report accesses so that the recency order stays current.

A short miss history decides when to prefetch. Two accepted demand misses to adjacent line addresses queue the next two lines. Any other demand miss clears the queue. A queued line whose tag is already held is skipped without a bus request. Prefetched lines are installed at the least-recent position. A demand miss that arrives while a prefetch is on the bus waits only for the current beat to end. If that beat was the lower half, the partial prefetch line is dropped.

Top module: `l2_refill_engine`

## Requirements
- R1: A line fill makes two bus requests for the same line: first `bus_half`=0 (lower 64 bytes), then `bus_half`=1 (upper 64 bytes). `fill_data` carries the lower beat in bits [511:0] and the upper beat in bits [1023:512].
- R2: `fill_valid` is a one-cycle pulse. It is raised only in the cycle in which `bus_rvalid` delivers the upper half, never after the lower half.
- R3: `bus_req` stays high with `bus_line` and `bus_half` unchanged until a cycle with `bus_gnt`. Only one request is outstanding at a time.
- R4: `fill_way` is the least-recently-used way of the set, where the set is `line[1:0]` with the default four sets. After reset, successive demand fills to one set pick ways 7, 6, 5, 4, 3, 2, 1, 0 and then 7 again. A demand fill becomes most-recently used.
- R5: `hit_valid` on a line held in the engine's tags makes that way most-recently used.
- R6: When an accepted demand miss to line L follows an accepted demand miss to L-1, the engine fetches L+1 and then L+2 after L's fill. Each takes two half requests, and each fill has `fill_pref`=1.
- R7: A demand miss whose line is not one above the previous demand miss causes exactly two bus requests and one fill, with no prefetch.
- R8: A queued prefetch line already held in the tags issues no bus request. The engine moves on to the next queued line.
- R9: A demand miss raised during a prefetch beat is accepted after that beat ends. If the beat was a lower half, that prefetch line is abandoned and no fill is made for it. The demand's own requests come next.
- R10: A prefetch fill leaves the set's recency order unchanged. The next demand fill to that set therefore reuses the prefetched line's way.
- R11: `miss_ready` is high only when no bus transfer is active. A demand miss pending with queued prefetches is accepted before any of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Demand miss present |
| miss_line | input | 12 | Line address of the demand miss |
| miss_ready | output | 1 | Demand miss accepted this cycle when valid |
| hit_valid | input | 1 | Cache hit report |
| hit_line | input | 12 | Line address of the hit |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant for the current request |
| bus_line | output | 12 | Line address of the request |
| bus_half | output | 1 | 0 = lower 64 bytes, 1 = upper 64 bytes |
| bus_rvalid | input | 1 | Response beat valid |
| bus_rdata | input | 512 | Response beat data |
| fill_valid | output | 1 | Assembled line ready for the arrays |
| fill_line | output | 12 | Line address being installed |
| fill_way | output | 3 | Way receiving the line |
| fill_pref | output | 1 | Line came from a prefetch |
| fill_data | output | 1024 | Full line, lower half in low bits |

## Verification
The bench targets the victim order after reset and after a hit. An engine with a broken age update would repeat or skip ways. It also targets a prefetch into a set whose next demand fill must reuse the same way. A design that ranked prefetches as recent would evict a live line there instead. A prefetch target that is already present must produce no request for it, so a missing presence check shows up as an extra bus request. A demand miss injected on the lower beat of a prefetch must be served next, with no fill for the abandoned line. A design that finished the prefetch first, or installed half a line, breaks the expected request and fill sequence.

// File: rtl/l2_refill_engine.sv
module l2_refill_engine #(
  parameter int LINE_W = 12,
  parameter int SETS   = 4,
  parameter int WAYS   = 8,
  parameter int BEAT_W = 512
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      miss_valid,
  input  logic [LINE_W-1:0]         miss_line,
  output logic                      miss_ready,
  input  logic                      hit_valid,
  input  logic [LINE_W-1:0]         hit_line,
  output logic                      bus_req,
  input  logic                      bus_gnt,
  output logic [LINE_W-1:0]         bus_line,
  output logic                      bus_half,
  input  logic                      bus_rvalid,
  input  logic [BEAT_W-1:0]         bus_rdata,
  output logic                      fill_valid,
  output logic [LINE_W-1:0]         fill_line,
  output logic [$clog2(WAYS)-1:0]   fill_way,
  output logic                      fill_pref,
  output logic [2*BEAT_W-1:0]       fill_data
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = LINE_W - SET_W;
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [LINE_W-1:0] cur_line, pf_next, last_miss;
  logic              cur_half, cur_pref, last_ok;
  logic [1:0]        pf_left;
  logic [BEAT_W-1:0] lo_q;
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAY_W-1:0]  age_q [SETS][WAYS];
  logic [WAY_W-1:0]  age_d [SETS][WAYS];

  logic [SET_W-1:0]  cs, ps, hs;
  logic [WAY_W-1:0]  vway, hway;
  logic [WAYS-1:0]   lru_vec;
  logic              pf_hit, hit_found, hit_do, beat_done, install;

  assign cs = cur_line[SET_W-1:0];
  assign ps = pf_next[SET_W-1:0];
  assign hs = hit_line[SET_W-1:0];

  assign beat_done  = (st == S_WAIT) && bus_rvalid;
  assign install    = beat_done && cur_half;
  assign miss_ready = (st == S_IDLE);
  assign bus_req    = (st == S_REQ);
  assign bus_line   = cur_line;
  assign bus_half   = cur_half;
  assign fill_valid = install;
  assign fill_line  = cur_line;
  assign fill_way   = vway;
  assign fill_pref  = cur_pref;
  assign fill_data  = {bus_rdata, lo_q};

  always_comb begin
    vway = '0; hway = '0; pf_hit = 1'b0; hit_found = 1'b0; lru_vec = '0;
    for (int w = 0; w < WAYS; w++) begin
      lru_vec[w] = (age_q[cs][w] == OLDEST);
      if (lru_vec[w]) vway = WAY_W'(w);
      if (vld_q[ps][w] && tag_q[ps][w] == pf_next[LINE_W-1:SET_W]) pf_hit = 1'b1;
      if (vld_q[hs][w] && tag_q[hs][w] == hit_line[LINE_W-1:SET_W]) begin
        hit_found = 1'b1;
        hway = WAY_W'(w);
      end
    end
  end

  assign hit_do = hit_valid && hit_found && !(install && hs == cs);

  always_comb begin
    age_d = age_q;
    if (hit_do)
      for (int w = 0; w < WAYS; w++)
        if (WAY_W'(w) == hway) age_d[hs][w] = '0;
        else if (age_q[hs][w] < age_q[hs][hway]) age_d[hs][w] = age_q[hs][w] + 1'b1;
    if (install && !cur_pref)
      for (int w = 0; w < WAYS; w++)
        if (WAY_W'(w) == vway) age_d[cs][w] = '0;
        else if (age_q[cs][w] < age_q[cs][vway]) age_d[cs][w] = age_q[cs][w] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur_line <= '0; cur_half <= 1'b0; cur_pref <= 1'b0;
      pf_next <= '0; pf_left <= '0; last_miss <= '0; last_ok <= 1'b0;
      lo_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else begin
      age_q <= age_d;
      if (install) begin
        tag_q[cs][vway] <= cur_line[LINE_W-1:SET_W];
        vld_q[cs][vway] <= 1'b1;
      end
      case (st)
        S_IDLE:
          if (miss_valid) begin
            cur_line <= miss_line; cur_half <= 1'b0; cur_pref <= 1'b0;
            st <= S_REQ;
            last_miss <= miss_line; last_ok <= 1'b1;
            if (last_ok && miss_line == last_miss + 1'b1) begin
              pf_next <= miss_line + 1'b1;
              pf_left <= 2'd2;
            end else pf_left <= '0;
          end else if (pf_left != 0) begin
            if (pf_hit) begin
              pf_next <= pf_next + 1'b1;
              pf_left <= pf_left - 1'b1;
            end else begin
              cur_line <= pf_next; cur_half <= 1'b0; cur_pref <= 1'b1;
              st <= S_REQ;
            end
          end
        S_REQ:
          if (bus_gnt) st <= S_WAIT;
        S_WAIT:
          if (bus_rvalid) begin
            if (!cur_half) begin
              lo_q <= bus_rdata;
              if (cur_pref && miss_valid) st <= S_IDLE;
              else begin
                cur_half <= 1'b1;
                st <= S_REQ;
              end
            end else begin
              st <= S_IDLE;
              if (cur_pref) begin
                pf_next <= pf_next + 1'b1;
                pf_left <= pf_left - 1'b1;
              end
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_line) && $stable(bus_half));

  p_upper_after_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) && bus_half |-> $past(bus_rvalid));

  p_accept_issues_r11: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> bus_req && !bus_half && bus_line == $past(miss_line));

  p_lru_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(lru_vec));

  p_fill_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid);
endmodule

// File: tb/l2_refill_engine_test.sv
`timescale 1ns/1ps
module l2_refill_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_valid = 1'b0, hit_valid = 1'b0;
  logic [11:0] miss_line = '0, hit_line = '0;
  logic miss_ready, bus_req, bus_half, fill_valid, fill_pref;
  logic bus_gnt, bus_rvalid;
  logic [11:0] bus_line, fill_line;
  logic [2:0] fill_way;
  logic [511:0] bus_rdata;
  logic [1023:0] fill_data;

  always #2 clk = ~clk;

  l2_refill_engine uut (.clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
    .miss_ready(miss_ready), .hit_valid(hit_valid), .hit_line(hit_line), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_line(bus_line), .bus_half(bus_half), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .fill_valid(fill_valid), .fill_line(fill_line), .fill_way(fill_way),
    .fill_pref(fill_pref), .fill_data(fill_data));

  int checks = 0, failures = 0, nreq = 0, nfill = 0;
  logic [11:0] rq_line [256];
  logic        rq_half [256];
  logic [11:0] fl_line [256];
  logic [2:0]  fl_way  [256];
  logic        fl_pref [256];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] pat(input logic [11:0] l, input logic h);
    return {16{l, 3'b101, h, 16'hC3A5}};
  endfunction

  logic [11:0] bl;
  logic bh;
  int bd;
  initial begin
    bus_gnt = 1'b0; bus_rvalid = 1'b0; bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && bus_req) begin
        bl = bus_line; bh = bus_half; bd = nreq % 3;
        repeat (bd) begin
          @(negedge clk);
          chk(bus_req && bus_line == bl && bus_half == bh, "R3 hold", {bus_req, bus_line}, {1'b1, bl});
        end
        bus_gnt = 1'b1; rq_line[nreq] = bl; rq_half[nreq] = bh; nreq++;
        @(negedge clk); bus_gnt = 1'b0;
        @(negedge clk); bus_rvalid = 1'b1; bus_rdata = pat(bl, bh);
        @(negedge clk); bus_rvalid = 1'b0;
      end
    end
  end

  always begin
    @(negedge clk); #1;
    if (rst_n && fill_valid) begin
      chk(fill_data == {pat(fill_line, 1'b1), pat(fill_line, 1'b0)}, "R1 data",
          fill_data[543:512], pat(fill_line, 1'b1));
      chk(bus_rvalid && rq_half[nreq-1] && rq_line[nreq-1] == fill_line, "R2 upper beat",
          rq_half[nreq-1], 1);
      fl_line[nfill] = fill_line; fl_way[nfill] = fill_way; fl_pref[nfill] = fill_pref; nfill++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_miss(input logic [11:0] l);
    @(negedge clk);
    miss_valid = 1'b1; miss_line = l;
    #1;
    while (!miss_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic do_hit(input logic [11:0] l);
    @(negedge clk); hit_valid = 1'b1; hit_line = l;
    @(negedge clk); hit_valid = 1'b0;
  endtask

  // {line, expected way}: non-adjacent misses into set 0
  localparam logic [14:0] VEC [9] = '{
    {12'h040, 3'd7}, {12'h044, 3'd6}, {12'h048, 3'd5}, {12'h04C, 3'd4}, {12'h050, 3'd3},
    {12'h054, 3'd2}, {12'h058, 3'd1}, {12'h05C, 3'd0}, {12'h060, 3'd7}};

  bit done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int r0, f0, k;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!bus_req, "R3 reset", bus_req, 0);
    chk(!fill_valid, "R2 reset", fill_valid, 0);
    chk(miss_ready, "R11 reset", miss_ready, 1);

    for (int i = 0; i < 9; i++) begin
      r0 = nreq; f0 = nfill;
      do_miss(VEC[i][14:3]);
      idle(40);
      chk(nfill == f0 + 1 && nreq == r0 + 2, "R7 single fill", nreq - r0, 2);
      chk(rq_line[r0] == VEC[i][14:3] && !rq_half[r0] && rq_line[r0+1] == VEC[i][14:3] && rq_half[r0+1],
          "R1 order", {rq_half[r0], rq_half[r0+1]}, 2'b01);
      chk(fl_line[f0] == VEC[i][14:3] && !fl_pref[f0], "R4 line", fl_line[f0], VEC[i][14:3]);
      chk(fl_way[f0] == VEC[i][2:0], "R4 victim", fl_way[f0], VEC[i][2:0]);
    end

    do_hit(12'h044);
    f0 = nfill;
    do_miss(12'h080);
    idle(40);
    chk(fl_way[f0] == 3'd5, "R5 hit reorders", fl_way[f0], 5);

    do_miss(12'h101);
    idle(40);
    r0 = nreq; f0 = nfill;
    do_miss(12'h102);
    idle(100);
    chk(nreq == r0 + 6, "R6 request count", nreq - r0, 6);
    chk(rq_line[r0+2] == 12'h103 && !rq_half[r0+2] && rq_line[r0+3] == 12'h103 && rq_half[r0+3],
        "R6 first prefetch", rq_line[r0+2], 12'h103);
    chk(rq_line[r0+4] == 12'h104 && rq_line[r0+5] == 12'h104, "R6 second prefetch", rq_line[r0+4], 12'h104);
    chk(nfill == f0 + 3 && !fl_pref[f0] && fl_pref[f0+1] && fl_pref[f0+2], "R6 fill flags",
        {fl_pref[f0], fl_pref[f0+1], fl_pref[f0+2]}, 3'b011);
    chk(fl_way[f0+2] == 3'd4, "R6 prefetch way", fl_way[f0+2], 4);

    f0 = nfill;
    do_miss(12'h200);
    idle(40);
    chk(fl_way[f0] == 3'd4, "R10 prefetch at LRU", fl_way[f0], 4);

    do_miss(12'h207); idle(40);
    do_miss(12'h205); idle(40);
    r0 = nreq; f0 = nfill;
    do_miss(12'h206);
    idle(100);
    chk(nreq == r0 + 4, "R8 request count", nreq - r0, 4);
    chk(rq_line[r0+2] == 12'h208 && rq_line[r0+3] == 12'h208, "R8 present skipped", rq_line[r0+2], 12'h208);
    chk(nfill == f0 + 2 && fl_pref[f0+1] && fl_way[f0+1] == 3'd3, "R8 next prefetch", fl_way[f0+1], 3);

    do_miss(12'h301); idle(40);
    r0 = nreq;
    do_miss(12'h302);
    do begin @(negedge clk); #2; end
    while (!(nreq > r0 + 2 && rq_line[nreq-1] == 12'h303));
    k = nreq - 1; f0 = nfill;
    chk(!miss_ready, "R11 busy", miss_ready, 0);
    miss_valid = 1'b1; miss_line = 12'h303;
    while (!miss_ready) begin @(negedge clk); #1; end
    @(negedge clk); miss_valid = 1'b0;
    idle(100);
    chk(nreq == k + 7, "R9 request count", nreq - k, 7);
    chk(rq_line[k+1] == 12'h303 && !rq_half[k+1] && rq_line[k+2] == 12'h303 && rq_half[k+2],
        "R9 demand next", {rq_half[k+1], rq_half[k+2]}, 2'b01);
    chk(nfill == f0 + 3 && fl_line[f0] == 12'h303 && !fl_pref[f0], "R9 no partial fill",
        {fl_line[f0], fl_pref[f0]}, {12'h303, 1'b0});
    chk(fl_line[f0+1] == 12'h304 && fl_line[f0+2] == 12'h305, "R11 queue after demand",
        fl_line[f0+1], 12'h304);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule